// File: doc/BRIEF.md
# Cycle-Stealing Debug Slot Arbiter

This block shares a memory bus between a running CPU and a debug access port. A debug request waits first for a cycle in which the CPU leaves the bus unused, and takes that cycle so the program keeps running undisturbed. If no such cycle turns up within a fixed window, the block freezes the CPU and takes the bus by force. An operation longer than one cycle keeps the CPU frozen until its last access cycle, even when it began in a naturally free cycle.

When the CPU is already halted in background mode, every cycle counts as free and the debug access starts at once. The block only arbitrates. Address decoding and data transfer belong to the logic around it, which moves data in every cycle where the grant is high.

Top module: `dbgSlotArb`

## Requirements
- R1: After `dbgReq` is sampled high in idle, the arbiter waits from the next cycle on. The first waiting cycle with `cpuIdle` high drives `dbgGrant` high in that same cycle.
- R2: When `opLen` is 0 (one access cycle) and the grant falls in a free cycle, `cpuFreeze` stays low for the whole operation.
- R3: If none of the first TIMEOUT (128) waiting cycles is free, `cpuFreeze` and `dbgGrant` rise together in the next cycle and stay high for `opLen`+1 cycles.
- R4: A free cycle that arrives on the 128th waiting cycle is granted naturally, and no freeze follows for a single-cycle operation.
- R5: `opLen` = n requests n+1 access cycles. After a free first cycle, `dbgGrant` and `cpuFreeze` both stay high for the n cycles that follow it.
- R6: `dbgDone` is high for exactly the one cycle after the last access cycle. `dbgGrant` and `cpuFreeze` are low in that cycle.
- R7: With `bgActive` high, the first waiting cycle is granted whatever the value of `cpuIdle`.
- R8: `dbgReq` has no effect while an operation is in progress. Outside the waiting phase, `cpuIdle` has no effect. After `dbgDone` the outputs stay low until a new request arrives.
- R9: While `rstN` is low, `dbgGrant`, `cpuFreeze` and `dbgDone` are low.
- R10: The timeout count starts again from zero with every new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dbgReq | input | 1 | Debug access request, sampled only while idle |
| opLen | input | LEN_W | Access cycles minus one, captured with the request |
| cpuIdle | input | 1 | CPU leaves the bus unused in this cycle |
| bgActive | input | 1 | CPU halted in background mode |
| dbgGrant | output | 1 | Debug port owns the bus in this cycle |
| cpuFreeze | output | 1 | CPU held off the bus |
| dbgDone | output | 1 | One-cycle completion pulse |

## Verification
A natural free cycle and the timeout can land on the same cycle. This happens when `cpuIdle` rises on exactly the 128th waiting cycle, the last cycle in which the counter has not yet expired. The bench provokes this case with every operation length. It judges the result by requiring that the grant falls in that same cycle, with no freeze for a one-cycle operation. Runs whose free cycle arrives one cycle later are checked as well, and they must show the forced path starting at cycle 129.

// File: rtl/dbgArbPkg.sv
package dbgArbPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_ACCESS = 2'd2,
    ST_DONE   = 2'd3
  } arbState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic startReq;
    logic stepWait;
    logic loadFree;
    logic loadForce;
    logic stepAccess;
  } arbStrobe_t;

  // datapath -> control flags
  typedef struct packed {
    logic waitLast;
    logic extraZero;
    logic accessLast;
  } arbStatus_t;

endpackage

// File: rtl/dbgArbDatapath.sv
module dbgArbDatapath
  import dbgArbPkg::*;
#(
  parameter int TIMEOUT = 128,
  parameter int LEN_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  arbStrobe_t       strobe,
  input  logic [LEN_W-1:0] opLen,
  output arbStatus_t       status
);
  localparam int WAIT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam int CNT_W  = LEN_W + 1;
  localparam logic [WAIT_W-1:0] WAIT_END = WAIT_W'(TIMEOUT - 1);

  logic [WAIT_W-1:0] waitCnt;
  logic [LEN_W-1:0]  extraLen;
  logic [CNT_W-1:0]  leftCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt  <= '0;
      extraLen <= '0;
      leftCnt  <= '0;
    end else begin
      if (strobe.startReq) begin
        waitCnt  <= '0;
        extraLen <= opLen;
      end else if (strobe.stepWait) begin
        waitCnt <= waitCnt + 1'b1;
      end

      if (strobe.loadFree)
        leftCnt <= {1'b0, extraLen};
      else if (strobe.loadForce)
        leftCnt <= {1'b0, extraLen} + 1'b1;
      else if (strobe.stepAccess)
        leftCnt <= leftCnt - 1'b1;
    end
  end

  always_comb begin
    status.waitLast   = (waitCnt == WAIT_END);
    status.extraZero  = (extraLen == '0);
    status.accessLast = (leftCnt == CNT_W'(1));
  end

endmodule

// File: rtl/dbgArbControl.sv
module dbgArbControl
  import dbgArbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dbgReq,
  input  logic       cpuIdle,
  input  logic       bgActive,
  input  arbStatus_t status,
  output arbStrobe_t strobe,
  output logic       dbgGrant,
  output logic       cpuFreeze,
  output logic       dbgDone
);
  arbState_t state, nextState;
  logic slotFree;

  assign slotFree = cpuIdle | bgActive;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    dbgGrant  = 1'b0;
    cpuFreeze = 1'b0;
    dbgDone   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (dbgReq) begin
          strobe.startReq = 1'b1;
          nextState       = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (slotFree) begin
          dbgGrant = 1'b1;
          if (status.extraZero) begin
            nextState = ST_DONE;
          end else begin
            strobe.loadFree = 1'b1;
            nextState       = ST_ACCESS;
          end
        end else if (status.waitLast) begin
          strobe.loadForce = 1'b1;
          nextState        = ST_ACCESS;
        end else begin
          strobe.stepWait = 1'b1;
        end
      end
      ST_ACCESS: begin
        dbgGrant          = 1'b1;
        cpuFreeze         = 1'b1;
        strobe.stepAccess = 1'b1;
        if (status.accessLast) nextState = ST_DONE;
      end
      ST_DONE: begin
        dbgDone   = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/dbgSlotArb.sv
module dbgSlotArb
  import dbgArbPkg::*;
#(
  parameter int TIMEOUT = 128,
  parameter int LEN_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dbgReq,
  input  logic [LEN_W-1:0] opLen,
  input  logic             cpuIdle,
  input  logic             bgActive,
  output logic             dbgGrant,
  output logic             cpuFreeze,
  output logic             dbgDone
);
  arbStrobe_t strobe;
  arbStatus_t status;

  dbgArbControl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .dbgReq    (dbgReq),
    .cpuIdle   (cpuIdle),
    .bgActive  (bgActive),
    .status    (status),
    .strobe    (strobe),
    .dbgGrant  (dbgGrant),
    .cpuFreeze (cpuFreeze),
    .dbgDone   (dbgDone)
  );

  dbgArbDatapath #(.TIMEOUT(TIMEOUT), .LEN_W(LEN_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .opLen  (opLen),
    .status (status)
  );

endmodule

// File: rtl/dbgSlotArbChecker.sv
module dbgSlotArbChecker (
  input logic clk,
  input logic rstN,
  input logic cpuIdle,
  input logic bgActive,
  input logic dbgGrant,
  input logic cpuFreeze,
  input logic dbgDone
);
  // R1/R2: a grant without freeze is only taken in a free cycle
  p_unfrozen_grant_free_r1: assert property (@(posedge clk) disable iff (!rstN)
    (dbgGrant && !cpuFreeze) |-> (cpuIdle || bgActive));

  // R5: the CPU is only frozen while the debug port owns the bus
  p_freeze_has_grant_r5: assert property (@(posedge clk) disable iff (!rstN)
    cpuFreeze |-> dbgGrant);

  // R6: freeze release coincides with the done pulse
  p_release_with_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuFreeze) |-> dbgDone);

  // R6: done lasts a single cycle
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    dbgDone |=> !dbgDone);

  // R6: done arrives only right after an access cycle
  p_done_after_access_r6: assert property (@(posedge clk) disable iff (!rstN)
    dbgDone |-> ($past(dbgGrant) && !dbgGrant && !cpuFreeze));

  // R3: a freeze that starts without a preceding grant follows a busy cycle
  p_forced_after_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cpuFreeze) && !$past(dbgGrant)) |-> $past(!cpuIdle && !bgActive));

  // R9: outputs quiet in reset
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r9: assert (!dbgGrant && !cpuFreeze && !dbgDone);
    end
  end

endmodule

bind dbgSlotArb dbgSlotArbChecker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cpuIdle   (cpuIdle),
  .bgActive  (bgActive),
  .dbgGrant  (dbgGrant),
  .cpuFreeze (cpuFreeze),
  .dbgDone   (dbgDone)
);

// File: tb/dbgSlotArb_bench.sv
module dbgSlotArb_bench;
  localparam int TIMEOUT = 128;
  localparam int LEN_W   = 4;
  localparam int NONE    = 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dbgReq = 1'b0;
  logic [LEN_W-1:0] opLen = '0;
  logic cpuIdle = 1'b0;
  logic bgActive = 1'b0;
  logic dbgGrant, cpuFreeze, dbgDone;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dbgSlotArb #(.TIMEOUT(TIMEOUT), .LEN_W(LEN_W)) u_dbgSlotArb (
    .clk(clk), .rstN(rstN), .dbgReq(dbgReq), .opLen(opLen),
    .cpuIdle(cpuIdle), .bgActive(bgActive),
    .dbgGrant(dbgGrant), .cpuFreeze(cpuFreeze), .dbgDone(dbgDone)
  );

  task automatic chk(input logic act, input logic exp, input string tag,
                     input string what, input int t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s t=%0d actual=%0b expected=%0b", tag, what, t, act, exp);
    end
  endtask

  // freeAt: waiting cycle (1-based) with cpuIdle high; busyReq: cycle to re-pulse dbgReq
  task automatic runOne(input int freeAt, input int n, input logic bg,
                        input int busyReq, input logic restartTag);
    int start;
    int lastT;
    logic forced;
    string gTag, fTag;
    @(negedge clk);
    dbgReq = 1'b1; opLen = LEN_W'(n); cpuIdle = 1'b0; bgActive = bg;
    @(negedge clk);
    dbgReq = 1'b0;
    start  = bg ? 1 : ((freeAt <= TIMEOUT) ? freeAt : TIMEOUT + 1);
    forced = !bg && (freeAt > TIMEOUT);
    lastT  = start + n + 5;
    if (forced)               gTag = restartTag ? "R10" : "R3";
    else if (bg)              gTag = "R7";
    else if (freeAt == TIMEOUT) gTag = "R4";
    else                      gTag = "R1";
    if (forced)      fTag = restartTag ? "R10" : "R3";
    else if (n == 0) fTag = (freeAt == TIMEOUT) ? "R4" : "R2";
    else             fTag = "R5";
    for (int t = 1; t <= lastT; t++) begin
      // cpuIdle toggles freely outside the waiting phase (R8)
      cpuIdle = (t == freeAt) || (t > start && t[0]);
      dbgReq  = (t == busyReq);
      #3;
      if (t < start) begin
        chk(dbgGrant, 1'b0, gTag, "grant-wait", t);
        chk(cpuFreeze, 1'b0, fTag, "freeze-wait", t);
      end else if (t <= start + n) begin
        chk(dbgGrant, 1'b1, (t == start) ? gTag : "R5", "grant-access", t);
        chk(cpuFreeze, forced || (t > start), fTag, "freeze-access", t);
      end else begin
        chk(dbgGrant, 1'b0, (t == start + n + 1) ? "R6" : "R8", "grant-after", t);
        chk(cpuFreeze, 1'b0, (t == start + n + 1) ? "R6" : "R8", "freeze-after", t);
      end
      chk(dbgDone, (t == start + n + 1), (t <= start + n + 1) ? "R6" : "R8", "done", t);
      @(negedge clk);
    end
    dbgReq = 1'b0; cpuIdle = 1'b0; bgActive = 1'b0;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int freeList[7];
    freeList = '{1, 2, 3, 64, 127, TIMEOUT, NONE};
    // R9: reset state, with inputs active
    dbgReq = 1'b1; cpuIdle = 1'b1; bgActive = 1'b1;
    repeat (3) @(negedge clk);
    chk(dbgGrant, 1'b0, "R9", "reset-grant", 0);
    chk(cpuFreeze, 1'b0, "R9", "reset-freeze", 0);
    chk(dbgDone, 1'b0, "R9", "reset-done", 0);
    dbgReq = 1'b0; cpuIdle = 1'b0; bgActive = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    // Sweep free-cycle position against operation length (R1..R6)
    foreach (freeList[i]) begin
      for (int n = 0; n < 4; n++) runOne(freeList[i], n, 1'b0, 0, 1'b0);
      runOne(freeList[i], 15, 1'b0, 0, 1'b0);
    end
    // Free cycle one past the window: forced path wins (R3, R4 boundary)
    runOne(TIMEOUT + 1, 0, 1'b0, 0, 1'b0);
    // Background mode: immediate grant (R7)
    for (int n = 0; n < 3; n++) runOne(NONE, n, 1'b1, 0, 1'b0);
    // Request pulsed during access and wait: ignored (R8)
    runOne(2, 3, 1'b0, 3, 1'b0);
    runOne(5, 1, 1'b0, 4, 1'b0);
    // Back-to-back timeouts: counter restarts per request (R10)
    runOne(NONE, 2, 1'b0, 0, 1'b1);
    runOne(NONE, 2, 1'b0, 0, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule